// File: doc/BRIEF.md
# Receive DMA Context Error Handler

This block decides what a receive DMA context does when a packet cannot be stored in host memory. It watches a host bus error strobe and an input FIFO overrun strobe, the start and end markers of packets leaving the input FIFO, the context's buffer mode and its run bit. From these it produces the context's dead flag, an event code, interrupt pulses, a descriptor status write-back pulse, a buffer rollback command and commands for the FIFO.

The response depends on the error kind and the buffer mode. In buffer-fill mode a host bus error is fatal. The context dies and records which descriptor held the failing address. The unrecoverable-error interrupt fires, the context's own interrupt is suppressed, and the FIFO is flushed. A buffer-fill overrun is not fatal. The packet is withdrawn from the buffer by restoring the write pointer and residual count captured at packet start, and its remaining bytes are dropped. In packet-per-buffer mode either error loads an event code, conditionally writes back the descriptor status and drops the rest of the packet. The context keeps running.

All outputs are registered. A strobe sampled at one rising edge shows its effect on the outputs right after that edge.

Top module: `rx_ctx_err_handler`

## Requirements
- R1: A synchronous reset clears every output: dead, interrupt pulses, write-back, rollback, drop and flush are 0, and the event code, rollback pointer and count, and saved descriptor are all 0.
- R2: In buffer-fill mode (`mode_fill`=1), a host bus error on a live context sets `dead`, loads event code 5'h07 (data write error) and pulses `unrec_irq` for one cycle. In that cycle `ctx_irq` and `stat_wb` stay 0 even when `desc_irq_req` is 1.
- R3: On that fatal error, `saved_desc` takes the `desc_addr` value presented in the error cycle and holds it afterwards, even after the run bit is cleared.
- R4: After a fatal error, `fifo_flush` is 1 and `fifo_drop` is 0 for as long as the context stays dead.
- R5: `dead` stays set until `run` is sampled low. While dead, all strobes are ignored: no pulses, no event change, no rollback.
- R6: In buffer-fill mode, an overrun without a host bus error pulses `rollback` for one cycle. `rb_ptr` and `rb_cnt` carry the `wr_ptr` and `res_cnt` sampled at the last accepted packet start. There is no `stat_wb`, `dead` and the event code are unchanged, and `fifo_drop` stays 1 until the packet's end marker has been sampled.
- R7: In packet-per-buffer mode (`mode_fill`=0), a host bus error loads event 5'h07 and an overrun loads event 5'h05 (overrun). `stat_wb` pulses only if a packet is open, `fifo_drop` rises, and `dead` stays 0.
- R8: When a host bus error and an overrun are sampled together, the host bus error wins: event 5'h07 and no rollback.
- R9: When an open, error-free packet ends, `stat_wb` pulses and `ctx_irq` pulses if `desc_irq_req` is 1. When a dropped packet ends, neither pulses.
- R10: While `run` is 0, all strobes are ignored, including packet starts, so the rollback snapshot is not replaced.
- R11: An error sampled in the same cycle as its packet's end marker leaves `fifo_drop` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Context run bit; low clears the dead state |
| mode_fill | input | 1 | 1 = buffer-fill, 0 = packet-per-buffer |
| desc_irq_req | input | 1 | Interrupt field of the current descriptor |
| pkt_start | input | 1 | First word of a packet leaves the FIFO |
| pkt_end | input | 1 | Last word of a packet leaves the FIFO |
| hb_err | input | 1 | Host bus write error strobe |
| ovr_err | input | 1 | Input FIFO overrun strobe |
| desc_addr | input | AW | Address of the current descriptor |
| wr_ptr | input | PW | Current buffer write pointer |
| res_cnt | input | CW | Current residual byte count |
| dead | output | 1 | Context has stopped on a fatal error |
| event_code | output | 5 | Last error event code |
| unrec_irq | output | 1 | Unrecoverable-error interrupt pulse |
| ctx_irq | output | 1 | Per-context interrupt pulse |
| stat_wb | output | 1 | Descriptor status write-back pulse |
| rollback | output | 1 | Restore buffer pointer and count pulse |
| rb_ptr | output | PW | Write pointer to restore |
| rb_cnt | output | CW | Residual count to restore |
| fifo_drop | output | 1 | Discard the rest of the current packet |
| fifo_flush | output | 1 | Discard everything queued for the context |
| saved_desc | output | AW | Descriptor holding the failing address |

## Verification
The assertions check on every cycle that the dead flag only clears through the run bit, and that no per-context interrupt, write-back or rollback appears while the context is dead. They also check that a drop ends with its packet and that a simultaneous host bus error and overrun never yields a rollback. Only the bench's scenarios can show the values carried: that the rollback returns the exact pointer and count of the matching packet start, that the saved descriptor is the one from the failing cycle, and that an ignored packet start under a low run bit leaves the snapshot alone.

// File: rtl/rxe_pkg.sv
package rxe_pkg;
  localparam int EVT_W = 5;
  localparam logic [EVT_W-1:0] EVT_NONE       = 5'h00;
  localparam logic [EVT_W-1:0] EVT_OVERRUN    = 5'h05;
  localparam logic [EVT_W-1:0] EVT_DATA_WRITE = 5'h07;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_KILL,
    ACT_ROLLBACK,
    ACT_PPB_ERR
  } act_e;
endpackage

// File: rtl/rxe_classify.sv
module rxe_classify
  import rxe_pkg::*;
(
  input  logic             active,
  input  logic             mode_fill,
  input  logic             hb_err,
  input  logic             ovr_err,
  output act_e             act,
  output logic [EVT_W-1:0] evt
);
  // host bus error outranks overrun (R8)
  always_comb begin
    act = ACT_NONE;
    evt = EVT_NONE;
    if (active) begin
      if (hb_err) begin
        act = mode_fill ? ACT_KILL : ACT_PPB_ERR;
        evt = EVT_DATA_WRITE;
      end else if (ovr_err) begin
        act = mode_fill ? ACT_ROLLBACK : ACT_PPB_ERR;
        evt = EVT_OVERRUN;
      end
    end
  end
endmodule

// File: rtl/rxe_snapshot.sv
module rxe_snapshot #(
  parameter int PW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [PW-1:0] ptr_in,
  input  logic [CW-1:0] cnt_in,
  output logic [PW-1:0] ptr_q,
  output logic [CW-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (capture) begin
      ptr_q <= ptr_in;
      cnt_q <= cnt_in;
    end
  end
endmodule

// File: rtl/rxe_pkt_track.sv
module rxe_pkt_track (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic start,
  input  logic pend,
  input  logic err,
  output logic in_pkt,
  output logic drop
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      in_pkt <= 1'b0;
      drop   <= 1'b0;
    end else begin
      if (start)     in_pkt <= 1'b1;
      else if (pend) in_pkt <= 1'b0;
      if (pend)      drop <= 1'b0;
      else if (err)  drop <= 1'b1;
    end
  end

  // a packet end always closes the drop window (R6, R11)
  p_drop_ends_r6: assert property (@(posedge clk) disable iff (rst)
    pend |=> !drop);
endmodule

// File: rtl/rx_ctx_err_handler.sv
module rx_ctx_err_handler
  import rxe_pkg::*;
#(
  parameter int AW = 16,
  parameter int PW = 16,
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             mode_fill,
  input  logic             desc_irq_req,
  input  logic             pkt_start,
  input  logic             pkt_end,
  input  logic             hb_err,
  input  logic             ovr_err,
  input  logic [AW-1:0]    desc_addr,
  input  logic [PW-1:0]    wr_ptr,
  input  logic [CW-1:0]    res_cnt,
  output logic             dead,
  output logic [EVT_W-1:0] event_code,
  output logic             unrec_irq,
  output logic             ctx_irq,
  output logic             stat_wb,
  output logic             rollback,
  output logic [PW-1:0]    rb_ptr,
  output logic [CW-1:0]    rb_cnt,
  output logic             fifo_drop,
  output logic             fifo_flush,
  output logic [AW-1:0]    saved_desc
);
  logic             active;
  logic             start_g, end_g;
  act_e             act;
  logic [EVT_W-1:0] evt_c;
  logic [PW-1:0]    snap_ptr;
  logic [CW-1:0]    snap_cnt;
  logic             in_pkt;

  assign active  = run && !dead;
  assign start_g = pkt_start && active;
  assign end_g   = pkt_end && active;

  rxe_classify u_cls (
    .active(active), .mode_fill(mode_fill), .hb_err(hb_err),
    .ovr_err(ovr_err), .act(act), .evt(evt_c)
  );

  rxe_snapshot #(.PW(PW), .CW(CW)) u_snap (
    .clk(clk), .rst(rst), .capture(start_g), .ptr_in(wr_ptr),
    .cnt_in(res_cnt), .ptr_q(snap_ptr), .cnt_q(snap_cnt)
  );

  rxe_pkt_track u_trk (
    .clk(clk), .rst(rst), .clear(!run || act == ACT_KILL),
    .start(start_g), .pend(end_g), .err(act != ACT_NONE),
    .in_pkt(in_pkt), .drop(fifo_drop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dead       <= 1'b0;
      fifo_flush <= 1'b0;
      event_code <= EVT_NONE;
      unrec_irq  <= 1'b0;
      ctx_irq    <= 1'b0;
      stat_wb    <= 1'b0;
      rollback   <= 1'b0;
      rb_ptr     <= '0;
      rb_cnt     <= '0;
      saved_desc <= '0;
    end else begin
      unrec_irq <= 1'b0;
      ctx_irq   <= 1'b0;
      stat_wb   <= 1'b0;
      rollback  <= 1'b0;
      if (!run) begin
        dead       <= 1'b0;
        fifo_flush <= 1'b0;
      end
      unique case (act)
        ACT_KILL: begin
          dead       <= 1'b1;
          fifo_flush <= 1'b1;
          event_code <= evt_c;
          unrec_irq  <= 1'b1;
          saved_desc <= desc_addr;
        end
        ACT_ROLLBACK: begin
          rollback <= 1'b1;
          rb_ptr   <= snap_ptr;
          rb_cnt   <= snap_cnt;
        end
        ACT_PPB_ERR: begin
          event_code <= evt_c;
          stat_wb    <= in_pkt;
        end
        default: begin
          if (end_g && in_pkt && !fifo_drop) begin
            stat_wb <= 1'b1;
            ctx_irq <= desc_irq_req;
          end
        end
      endcase
    end
  end

  p_dead_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (dead && run) |=> dead);
  p_unrec_kills_r2: assert property (@(posedge clk) disable iff (rst)
    unrec_irq |-> dead);
  p_dead_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    dead |-> (!ctx_irq && !stat_wb && !rollback));
  p_rb_alive_r6: assert property (@(posedge clk) disable iff (rst)
    rollback |-> (!dead && !stat_wb));
  p_flush_no_drop_r4: assert property (@(posedge clk) disable iff (rst)
    fifo_flush |-> !fifo_drop);
  p_hb_prio_r8: assert property (@(posedge clk) disable iff (rst)
    (run && !dead && hb_err && ovr_err) |=>
      (!rollback && event_code == EVT_DATA_WRITE));
  p_ppb_alive_r7: assert property (@(posedge clk) disable iff (rst)
    (run && !dead && !mode_fill) |=> !$rose(dead));
endmodule

// File: tb/sim_rx_ctx_err_handler.sv
`timescale 1ns/1ps
module sim_rx_ctx_err_handler;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 0, mode_fill = 0, desc_irq_req = 0, pkt_start = 0, pkt_end = 0;
  logic hb_err = 0, ovr_err = 0;
  logic [15:0] desc_addr = '0, wr_ptr = '0, res_cnt = '0;
  logic dead, unrec_irq, ctx_irq, stat_wb, rollback, fifo_drop, fifo_flush;
  logic [4:0] event_code;
  logic [15:0] rb_ptr, rb_cnt, saved_desc;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_ctx_err_handler u0 (.*);

  typedef struct packed {
    logic r, f, q, ps, pe, hb, ov;
    logic [15:0] da, wp, rc;
    logic xd, xu, xc, xw, xr, xdr, xfl;
    logic [4:0] xe;
    logic [15:0] xp, xn, xs;
    logic [3:0] rq;
  } vec_t;

  // r f q ps pe hb ov desc wptr rcnt | dead unrec cirq wb rb drop flush evt rbp rbc sdesc req
  localparam vec_t TBL [18] = '{
    '{1,1,0,1,0,0,0,16'hA0,16'd100,16'd50, 0,0,0,0,0,0,0,5'h00,16'd0,16'd0,16'h00,4'd6},
    '{1,1,1,0,0,0,1,16'hA0,16'd140,16'd10, 0,0,0,0,1,1,0,5'h00,16'd100,16'd50,16'h00,4'd6},
    '{1,1,1,0,1,0,0,16'hA0,16'd140,16'd10, 0,0,0,0,0,0,0,5'h00,16'd100,16'd50,16'h00,4'd9},
    '{1,1,1,1,0,0,0,16'hA4,16'd200,16'd80, 0,0,0,0,0,0,0,5'h00,16'd100,16'd50,16'h00,4'd9},
    '{1,1,1,0,1,0,0,16'hA4,16'd260,16'd20, 0,0,1,1,0,0,0,5'h00,16'd100,16'd50,16'h00,4'd9},
    '{1,0,0,1,0,0,0,16'hA8,16'd300,16'd64, 0,0,0,0,0,0,0,5'h00,16'd100,16'd50,16'h00,4'd7},
    '{1,0,0,0,0,0,1,16'hA8,16'd310,16'd54, 0,0,0,1,0,1,0,5'h05,16'd100,16'd50,16'h00,4'd7},
    '{1,0,1,0,1,0,0,16'hA8,16'd310,16'd54, 0,0,0,0,0,0,0,5'h05,16'd100,16'd50,16'h00,4'd9},
    '{1,0,0,1,0,0,0,16'hAC,16'd320,16'd64, 0,0,0,0,0,0,0,5'h05,16'd100,16'd50,16'h00,4'd7},
    '{1,0,0,0,0,1,1,16'hAC,16'd330,16'd54, 0,0,0,1,0,1,0,5'h07,16'd100,16'd50,16'h00,4'd8},
    '{1,0,0,0,1,0,0,16'hAC,16'd330,16'd54, 0,0,0,0,0,0,0,5'h07,16'd100,16'd50,16'h00,4'd9},
    '{1,1,0,1,0,0,0,16'hB4,16'd400,16'd5,  0,0,0,0,0,0,0,5'h07,16'd100,16'd50,16'h00,4'd6},
    '{1,1,1,0,0,1,1,16'hB8,16'd410,16'd3,  1,1,0,0,0,0,1,5'h07,16'd100,16'd50,16'hB8,4'd2},
    '{1,1,1,0,1,0,0,16'hB8,16'd410,16'd3,  1,0,0,0,0,0,1,5'h07,16'd100,16'd50,16'hB8,4'd5},
    '{1,1,0,0,0,0,1,16'hB8,16'd410,16'd3,  1,0,0,0,0,0,1,5'h07,16'd100,16'd50,16'hB8,4'd5},
    '{0,1,0,0,0,0,0,16'hB8,16'd410,16'd3,  0,0,0,0,0,0,0,5'h07,16'd100,16'd50,16'hB8,4'd3},
    '{1,1,0,1,0,0,0,16'hC0,16'd500,16'd7,  0,0,0,0,0,0,0,5'h07,16'd100,16'd50,16'hB8,4'd6},
    '{1,1,1,0,1,0,1,16'hC0,16'd520,16'd1,  0,0,0,0,1,0,0,5'h07,16'd500,16'd7,16'hB8,4'd11}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic r, f, q, ps, pe, hb, ov);
    run = r; mode_fill = f; desc_irq_req = q;
    pkt_start = ps; pkt_end = pe; hb_err = hb; ovr_err = ov;
  endtask

  task automatic step;
    @(negedge clk);
    drive(run, mode_fill, 0, 0, 0, 0, 0);
  endtask

  task automatic all_zero(input string req);
    chk(req, "dead", dead, 0);
    chk(req, "event", event_code, 0);
    chk(req, "pulses", {unrec_irq, ctx_irq, stat_wb, rollback}, 0);
    chk(req, "drop_flush", {fifo_drop, fifo_flush}, 0);
    chk(req, "rb", {rb_ptr, rb_cnt}, 0);
    chk(req, "saved", saved_desc, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    all_zero("R1");
    // table walk: inputs at falling edge, outputs checked one falling edge later
    for (int i = 0; i < 18; i++) begin
      string t;
      t = $sformatf("R%0d row%0d", TBL[i].rq, i);
      drive(TBL[i].r, TBL[i].f, TBL[i].q, TBL[i].ps, TBL[i].pe, TBL[i].hb, TBL[i].ov);
      desc_addr = TBL[i].da; wr_ptr = TBL[i].wp; res_cnt = TBL[i].rc;
      @(negedge clk);
      chk(t, "dead", dead, TBL[i].xd);
      chk(t, "unrec", unrec_irq, TBL[i].xu);
      chk(t, "ctx_irq", ctx_irq, TBL[i].xc);
      chk(t, "stat_wb", stat_wb, TBL[i].xw);
      chk(t, "rollback", rollback, TBL[i].xr);
      chk(t, "drop", fifo_drop, TBL[i].xdr);
      chk(t, "flush", fifo_flush, TBL[i].xfl);
      chk(t, "event", event_code, TBL[i].xe);
      chk(t, "rb_ptr", rb_ptr, TBL[i].xp);
      chk(t, "rb_cnt", rb_cnt, TBL[i].xn);
      chk(t, "saved", saved_desc, TBL[i].xs);
    end
    drive(1, 1, 0, 0, 1, 0, 0);
    step();

    // R10: strobes ignored with run low, snapshot kept
    wr_ptr = 16'd900; res_cnt = 16'd90; desc_addr = 16'hD0;
    drive(0, 1, 1, 1, 0, 1, 0);
    step();
    chk("R10", "dead", dead, 0);
    chk("R10", "unrec", unrec_irq, 0);
    chk("R10", "saved", saved_desc, 16'hB8);
    drive(1, 1, 0, 0, 0, 0, 1);
    step();
    chk("R10", "rollback", rollback, 1);
    chk("R10", "rb_ptr", rb_ptr, 16'd500);
    chk("R10", "rb_cnt", rb_cnt, 16'd7);
    chk("R6", "drop", fifo_drop, 1);
    drive(1, 1, 1, 0, 1, 0, 0);
    step();
    chk("R6", "drop_end", fifo_drop, 0);
    chk("R9", "no_irq_dropped", ctx_irq, 0);

    // R11: packet-per-buffer overrun on the packet's last cycle
    drive(1, 0, 0, 1, 0, 0, 0);
    step();
    drive(1, 0, 0, 0, 1, 0, 1);
    step();
    chk("R11", "drop", fifo_drop, 0);
    chk("R7", "stat_wb", stat_wb, 1);
    chk("R7", "event", event_code, 5'h05);

    // R7: error with no open packet gives no write-back
    drive(1, 0, 0, 0, 0, 1, 0);
    step();
    chk("R7", "wb_closed", stat_wb, 0);
    chk("R7", "event_dw", event_code, 5'h07);
    chk("R7", "alive", dead, 0);
    drive(1, 0, 0, 0, 1, 0, 0);
    step();

    // R5: dead holds over many cycles, then R1 reset clears it
    desc_addr = 16'hE4;
    drive(1, 1, 0, 0, 0, 1, 0);
    step();
    chk("R2", "dead", dead, 1);
    chk("R3", "saved", saved_desc, 16'hE4);
    for (int k = 0; k < 20; k++) begin
      drive(1, 1, 1, k[0], k[1], 0, k[2]);
      step();
      chk("R5", "dead_hold", dead, 1);
      chk("R4", "flush_hold", fifo_flush, 1);
      chk("R5", "quiet", {ctx_irq, stat_wb, rollback, unrec_irq}, 0);
    end
    rst = 1;
    @(negedge clk);
    rst = 0;
    all_zero("R1");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule